// File: doc/BRIEF.md
# Single-Level Page Table Translator

This unit sits between a processor and memory and turns every virtual address it receives into a physical one by consulting a flat page table in memory. For each accepted request it computes where the page-table entry lives, from a base register and the virtual page number, and reads that entry over a memory read port. That port is shared by entry fetches and data reads. A valid entry supplies the physical page number. The unit joins it with the untouched page offset, reads the data word and returns it.

An entry with its valid bit clear ends the transaction without any data read. Instead, a fault response carrying the virtual address goes back to the processor. Nothing is remembered between transactions. Reissuing an address after the handler has repaired the table therefore always fetches the entry again.

The base register is loaded through a write strobe that is honoured only while the unit is idle. The processor side uses a valid/ready handshake for both request and response. The memory side issues one request at a time, waits for a grant, and then waits any number of cycles for the read data.

Top module: `pt_xlate`

## Requirements
- R1: After a synchronous reset, req_ready is 1, rsp_valid is 0, mem_req is 0, and the base register holds 0.
- R2: The first memory read after a request is accepted targets (base + VPN*4) mod 2^PA_W, where VPN is vaddr[VA_W-1:PG_W].
- R3: When bit 31 of the fetched entry is 1, the unit makes a second read. Its address has the entry's bits [PA_W-PG_W-1:0] in the page-number field and vaddr[PG_W-1:0] in bits [PG_W-1:0]. The response carries the word returned by that read, with rsp_fault at 0.
- R4: When bit 31 of the fetched entry is 0, no further memory read is made, and the response has rsp_fault at 1 and rsp_data at 0.
- R5: Each accepted request yields exactly one response. That response echoes the request's virtual address and holds all its fields steady until rsp_ready is seen. req_ready is 1 only while no transaction is in progress.
- R6: At most one memory read is outstanding at a time. mem_req and mem_addr hold steady until mem_gnt, and mem_req stays low from a grant until the matching mem_rvalid.
- R7: mem_rvalid pulses that arrive while no read is outstanding have no effect on responses or on later translations.
- R8: A base write is taken only in a cycle where req_ready is 1, and one in the same cycle as a request acceptance is used by that request. A write while busy is ignored.
- R9: Reissuing an address that faulted fetches its entry from memory again and translates it from the current entry contents.
- R10: Asserting reset in the middle of a transaction drops it with no response, returns to idle, and clears the base register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_vaddr | input | VA_W | Virtual address of the request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_data | output | DATA_W | Data word read (0 on fault) |
| rsp_vaddr | output | VA_W | Virtual address the response belongs to |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | PA_W | Value for the base register |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_addr | output | PA_W | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench aims at the place where the entry address wraps past the top of physical space when the base is high. A design that carries the extra bit, or scales the page number wrongly, reads the wrong entry and returns the wrong word. It drives stray read-valid pulses while nothing is outstanding and stalls grants for random intervals. A unit that listens to rvalid in the wrong state, or drops its request before the grant, then swallows a bogus entry or loses an access. Base writes land during busy phases and in the very cycle of acceptance, which shows up any unit that updates the base mid-walk or latches it one cycle late. Faulting addresses are reissued before and after their entry is repaired, and a reset lands mid-walk; a unit that keeps stale translation state or leaks a response fails these cases.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTE_REQ,
        ST_PTE_WAIT,
        ST_DAT_REQ,
        ST_DAT_WAIT,
        ST_RESP
    } xl_state_e;

endpackage

// File: rtl/pt_va_split.sv
// Splits a virtual address and forms the byte address of its table entry.
module pt_va_split #(
    parameter int VA_W        = 16,
    parameter int PA_W        = 14,
    parameter int PG_W        = 8,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [VA_W-1:0]      vaddr_i,
    input  logic [PA_W-1:0]      base_i,
    output logic [VA_W-PG_W-1:0] vpn_o,
    output logic [PG_W-1:0]      ofs_o,
    output logic [PA_W-1:0]      pte_addr_o
);
    localparam int VPN_W = VA_W - PG_W;
    localparam int ESH   = $clog2(ENTRY_BYTES);

    logic [VPN_W+ESH-1:0] scaled;

    always_comb begin
        vpn_o      = vaddr_i[VA_W-1:PG_W];
        ofs_o      = vaddr_i[PG_W-1:0];
        scaled     = {vpn_o, {ESH{1'b0}}};
        pte_addr_o = base_i + PA_W'(scaled);
    end

endmodule

// File: rtl/pt_pte_decode.sv
// Decodes the fields of a fetched entry and builds the physical address.
module pt_pte_decode #(
    parameter int PA_W = 14,
    parameter int PG_W = 8
) (
    input  logic                 pte_valid_i,
    input  logic [PA_W-PG_W-1:0] pte_ppn_i,
    input  logic [PG_W-1:0]      ofs_i,
    output logic                 hit_o,
    output logic [PA_W-1:0]      paddr_o
);
    always_comb begin
        hit_o   = pte_valid_i;
        paddr_o = {pte_ppn_i, ofs_i};
    end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
    import pt_xlate_pkg::*;
#(
    parameter int VA_W      = 16,
    parameter int PA_W      = 14,
    parameter int PG_W      = 8,
    parameter int DATA_W    = 32,
    parameter int VALID_BIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_data,
    output logic [VA_W-1:0]   rsp_vaddr,
    input  logic              base_we,
    input  logic [PA_W-1:0]   base_wdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int VPN_W = VA_W - PG_W;
    localparam int PPN_W = PA_W - PG_W;

    typedef struct packed {
        xl_state_e         st;
        logic [VA_W-1:0]   va;
        logic [PA_W-1:0]   base;
        logic [PA_W-1:0]   pa;
        logic [DATA_W-1:0] data;
        logic              fault;
    } xl_regs_t;

    xl_regs_t r_q, r_d;

    logic [VPN_W-1:0] vpn;
    logic [PG_W-1:0]  ofs;
    logic [PA_W-1:0]  pte_addr;
    logic             pte_hit;
    logic [PA_W-1:0]  phys_addr;

    pt_va_split #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W), .ENTRY_BYTES(4)
    ) u_split (
        .vaddr_i   (r_q.va),
        .base_i    (r_q.base),
        .vpn_o     (vpn),
        .ofs_o     (ofs),
        .pte_addr_o(pte_addr)
    );

    pt_pte_decode #(
        .PA_W(PA_W), .PG_W(PG_W)
    ) u_dec (
        .pte_valid_i(mem_rdata[VALID_BIT]),
        .pte_ppn_i  (mem_rdata[PPN_W-1:0]),
        .ofs_i      (ofs),
        .hit_o      (pte_hit),
        .paddr_o    (phys_addr)
    );

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (base_we) r_d.base = base_wdata;
                if (req_valid) begin
                    r_d.va = req_vaddr;
                    r_d.st = ST_PTE_REQ;
                end
            end
            ST_PTE_REQ: begin
                if (mem_gnt) r_d.st = ST_PTE_WAIT;
            end
            ST_PTE_WAIT: begin
                if (mem_rvalid) begin
                    if (pte_hit) begin
                        r_d.pa = phys_addr;
                        r_d.st = ST_DAT_REQ;
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.data  = '0;
                        r_d.st    = ST_RESP;
                    end
                end
            end
            ST_DAT_REQ: begin
                if (mem_gnt) r_d.st = ST_DAT_WAIT;
            end
            ST_DAT_WAIT: begin
                if (mem_rvalid) begin
                    r_d.fault = 1'b0;
                    r_d.data  = mem_rdata;
                    r_d.st    = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.va    <= '0;
            r_q.base  <= '0;
            r_q.pa    <= '0;
            r_q.data  <= '0;
            r_q.fault <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready = (r_q.st == ST_IDLE);
        rsp_valid = (r_q.st == ST_RESP);
        rsp_fault = r_q.fault;
        rsp_data  = r_q.data;
        rsp_vaddr = r_q.va;
        mem_req   = (r_q.st == ST_PTE_REQ) || (r_q.st == ST_DAT_REQ);
        mem_addr  = (r_q.st == ST_PTE_REQ) ? pte_addr : r_q.pa;
    end

    // Assertions
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));                   // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> !mem_req);                                          // R6
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
            && $stable(rsp_fault) && $stable(rsp_vaddr)));                           // R5
    AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && rsp_valid));                                                  // R5
    AST_BASE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (base_we && !req_ready) |=> $stable(r_q.base));                              // R8
    AST_DATA_OFS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && r_q.st == ST_DAT_REQ) |-> (mem_addr[PG_W-1:0] == r_q.va[PG_W-1:0])); // R3
    AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_PTE_WAIT && mem_rvalid && !mem_rdata[VALID_BIT])
            |=> (rsp_valid && rsp_fault && !mem_req));                               // R4

endmodule

// File: tb/tb_pt_xlate.sv
module tb_pt_xlate;
    localparam int VA_W = 16;
    localparam int PA_W = 14;
    localparam int PG_W = 8;
    localparam int DW   = 32;

    logic            clk, rst;
    logic            req_valid, req_ready;
    logic [VA_W-1:0] req_vaddr;
    logic            rsp_valid, rsp_ready, rsp_fault;
    logic [DW-1:0]   rsp_data;
    logic [VA_W-1:0] rsp_vaddr;
    logic            base_we;
    logic [PA_W-1:0] base_wdata;
    logic            mem_req, mem_gnt, mem_rvalid;
    logic [PA_W-1:0] mem_addr;
    logic [DW-1:0]   mem_rdata;

    pt_xlate dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_data(rsp_data), .rsp_vaddr(rsp_vaddr),
        .base_we(base_we), .base_wdata(base_wdata),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    logic [31:0]     mem [0:4095];
    logic [PA_W-1:0] acc_addr [0:3];
    int              acc_n;
    int              n_chk, n_bad;
    bit              spur_en;
    logic [PA_W-1:0] base_m;

    // Memory responder
    bit              pending;
    int              lat;
    logic [PA_W-1:0] paddr;

    initial begin
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0; pending = 0; lat = 0; paddr = '0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                pending = 0; mem_gnt = 0; mem_rvalid = 0;
            end else begin
                mem_rvalid = 0;
                mem_rdata  = $urandom;
                if (pending) begin
                    if (lat == 0) begin
                        mem_rvalid = 1;
                        mem_rdata  = mem[paddr[PA_W-1:2]];
                        pending    = 0;
                    end else lat--;
                end else if (spur_en && ($urandom % 5 == 0)) begin
                    mem_rvalid = 1;
                end
                mem_gnt = mem_req && !pending && !mem_rvalid && ($urandom % 3 != 0);
                if (mem_gnt) begin
                    pending = 1;
                    lat     = $urandom % 3;
                    paddr   = mem_addr;
                    if (acc_n < 4) acc_addr[acc_n] = mem_addr;
                    acc_n++;
                end
            end
        end
    end

    function automatic logic [PA_W-1:0] pte_addr_f(input logic [PA_W-1:0] b, input logic [VA_W-1:0] va);
        logic [PA_W+1:0] s;
        s = {2'b00, b} + {6'd0, va[VA_W-1:PG_W], 2'b00};
        return s[PA_W-1:0];
    endfunction

    function automatic logic [PA_W-1:0] pa_f(input logic [31:0] pte, input logic [VA_W-1:0] va);
        return {pte[PA_W-PG_W-1:0], va[PG_W-1:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic write_base(input logic [PA_W-1:0] v);
        base_we = 1; base_wdata = v;
        @(negedge clk);
        base_we = 0;
        base_m  = v;
    endtask

    // One full transaction with checks. same_wr: base write in the acceptance cycle.
    task automatic xact(input logic [VA_W-1:0] va, input bit busy_wr,
                        input bit same_wr, input logic [PA_W-1:0] nb);
        logic [PA_W-1:0] ea, pa;
        logic [31:0]     pte, exp_d;
        bit              v;
        int              cnt;
        logic [DW-1:0]   d0;
        logic            f0;
        logic [VA_W-1:0] v0;
        if (same_wr) base_m = nb;
        ea    = pte_addr_f(base_m, va);
        pte   = mem[ea[PA_W-1:2]];
        v     = pte[31];
        pa    = pa_f(pte, va);
        exp_d = v ? mem[pa[PA_W-1:2]] : 32'd0;
        acc_n = 0;
        req_valid = 1; req_vaddr = va;
        if (same_wr) begin base_we = 1; base_wdata = nb; end
        cnt = 0;
        while (!req_ready && cnt < 100) begin @(negedge clk); cnt++; end
        @(negedge clk);
        req_valid = 0; base_we = 0;
        if (busy_wr) begin
            base_we = 1; base_wdata = PA_W'($urandom);
            @(negedge clk);
            base_we = 0;
        end
        cnt = 0;
        while (!rsp_valid && cnt < 300) begin @(negedge clk); cnt++; end
        chk(rsp_valid, "R5 response arrives", 32'(rsp_valid), 1);
        chk(!req_ready, "R5 not ready while responding", 32'(req_ready), 0);
        d0 = rsp_data; f0 = rsp_fault; v0 = rsp_vaddr;
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk(rsp_valid && rsp_data == d0 && rsp_fault == f0 && rsp_vaddr == v0,
                "R5 response held", rsp_data, d0);
        end
        chk(rsp_fault == !v, v ? "R3 hit not faulted" : "R4 fault flagged", 32'(rsp_fault), 32'(!v));
        chk(rsp_vaddr == va, "R5 vaddr echoed", 32'(rsp_vaddr), 32'(va));
        chk(rsp_data == exp_d, v ? "R3 data word" : "R4 fault data zero", rsp_data, exp_d);
        chk(acc_n == (v ? 2 : 1), v ? "R3 two reads" : "R4 no data read", 32'(acc_n), v ? 2 : 1);
        chk(acc_addr[0] == ea, same_wr ? "R8 same-cycle base used" : "R2 entry address",
            32'(acc_addr[0]), 32'(ea));
        if (v) chk(acc_addr[1] == pa, "R3 physical address", 32'(acc_addr[1]), 32'(pa));
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk(!rsp_valid && req_ready, "R5 single response", 32'(rsp_valid), 0);
    endtask

    // Watchdog
    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] ea;
        void'($urandom(32'd2718));
        n_chk = 0; n_bad = 0; acc_n = 0; spur_en = 0; base_m = '0;
        rst = 1; req_valid = 0; req_vaddr = '0; rsp_ready = 0; base_we = 0; base_wdata = '0;
        for (int i = 0; i < 4096; i++) mem[i] = {($urandom % 4 != 0), 31'($urandom)};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state; first walk uses base 0
        chk(req_ready, "R1 req_ready after reset", 32'(req_ready), 1);
        chk(!rsp_valid, "R1 no response after reset", 32'(rsp_valid), 0);
        chk(!mem_req, "R1 no memory request after reset", 32'(mem_req), 0);
        xact(16'h3A55, 0, 0, '0);   // R1 base is zero here

        // R2 wrap of entry address past top of physical space
        write_base(14'h3FF0);
        xact(16'hFF01, 0, 0, '0);
        xact(16'h0512, 0, 0, '0);

        // R8 write in acceptance cycle, then write while busy
        xact(16'h1234, 0, 1, 14'h0844);
        xact(16'h4321, 1, 0, '0);
        xact(16'h4322, 0, 0, '0);   // R8 busy write was ignored

        // R9 fault, reissue, repair, reissue
        va = 16'h7788;
        ea = pte_addr_f(base_m, va);
        mem[ea[PA_W-1:2]][31] = 1'b0;
        xact(va, 0, 0, '0);
        xact(va, 0, 0, '0);         // R9 entry fetched again
        mem[ea[PA_W-1:2]][31] = 1'b1;
        xact(va, 0, 0, '0);         // R9 repaired entry now hits

        // R10 reset in the middle of a walk
        req_valid = 1; req_vaddr = 16'hABCD;
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        base_m = '0;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R10 idle after mid-walk reset", 32'(rsp_valid), 0);
        chk(!mem_req, "R10 no request after reset", 32'(mem_req), 0);
        xact(16'h2468, 0, 0, '0);   // R10 base cleared to zero

        // R7 stray read-valid pulses, random traffic
        spur_en = 1;
        repeat (6) @(negedge clk);
        chk(!rsp_valid && req_ready, "R7 stray rvalid in idle", 32'(rsp_valid), 0);
        for (int k = 0; k < 300; k++) begin
            if ($urandom % 10 == 0) write_base(PA_W'($urandom));
            if ($urandom % 25 == 0) begin
                for (int i = 0; i < 64; i++) mem[$urandom % 4096] = $urandom;
            end
            xact(VA_W'($urandom), ($urandom % 6 == 0), ($urandom % 8 == 0), PA_W'($urandom));
        end
        spur_en = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule